// File: doc/BRIEF.md
# Predicated Contiguous Vector Load Sequencer

This block fills one vector register from a run of consecutive 64-bit memory words, with a mask deciding which lanes are loaded. A command gives a 64-bit base address, a per-lane mask and a destination register index. The block then walks the set mask bits from the lowest lane to the highest. For each one it issues a single read request on a valid/ready memory port and waits for the matching response before it moves to the next lane. Lanes whose mask bit is clear are never requested and end up as zero in the result.

After the last response, the assembled vector goes to the register file in one write cycle, and a done pulse follows in the next cycle. The vector width is a parameter, and the lane count is that width divided by 64. The block changes no condition flags and has no status output. A command that arrives while the block is working is dropped.

Top module: `vec_pred_load`

## Requirements
- R1: The vector holds VLEN/64 lanes of 64 bits each. Lane i of the result sits at rf_wdata_o bits [64*i+63 : 64*i] and, when its mask bit is set, holds the data returned for its request.
- R2: The read request for lane i carries the address base + 8*i, computed modulo 2^64.
- R3: A lane whose mask bit (pred_i bit i) is 0 is written as all zeros.
- R4: No request is issued for a lane whose mask bit is 0. Requests go out in ascending lane order, and no new request is raised while a response is still outstanding.
- R5: When the mask is all zeros, no request is issued and the register write happens in the cycle right after the command is accepted.
- R6: In the cycle after the last response arrives, rf_we_o is high for exactly one cycle with rf_waddr_o equal to the command's destination index. done_o is then high for exactly the following cycle.
- R7: busy_o is high from the cycle after a command is accepted up to and including the done cycle. A start_i seen while busy_o is high has no effect on requests, result or register index.
- R8: Reset clears busy and all pending state. A response that arrives after reset causes no write and no done pulse.
- R9: Once mem_req_valid_o is raised, it stays high and the address stays stable until mem_req_ready_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe, taken only when idle |
| base_addr_i | input | 64 | Address of lane 0 |
| pred_i | input | VLEN/64 | Per-lane mask, bit i for lane i |
| dst_idx_i | input | RIDX_W | Destination register index |
| busy_o | output | 1 | Command in progress |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 64 | Read address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Read data |
| rf_we_o | output | 1 | Register file write strobe |
| rf_waddr_o | output | RIDX_W | Register file write index |
| rf_wdata_o | output | VLEN | Full vector written |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check, on every cycle, the control protocol: requests are raised only for masked-in lanes, the lane index climbs between requests, a stalled request holds its address, write is followed by a single done pulse, the block stays quiet when idle, and inactive lanes are zero at the write. The correctness of the data (each lane's address and the returned value landing in the right slice) and the effect of a stray start or of reset on a response still in flight can only be shown by the bench. Its memory model returns address-derived data with random ready and response delays.

// File: rtl/vec_pred_load_pkg.sv
package vec_pred_load_pkg;
  localparam int unsigned ELEM_W = 64;
  localparam int unsigned ELEM_SHIFT = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } vpl_state_e;
endpackage

// File: rtl/vpl_lane_pick.sv
module vpl_lane_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     mask_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    idx_o   = '0;
    found_o = |mask_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vpl_addr_gen.sv
module vpl_addr_gen #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  import vec_pred_load_pkg::*;
  assign addr_o = base_i + ADDR_W'({idx_i, {ELEM_SHIFT{1'b0}}});
endmodule

// File: rtl/vpl_vec_assemble.sv
module vpl_vec_assemble #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     clear_i,
  input  logic                                     wr_en_i,
  input  logic [IDX_W-1:0]                         wr_idx_i,
  input  logic [vec_pred_load_pkg::ELEM_W-1:0]     wr_data_i,
  output logic [N*vec_pred_load_pkg::ELEM_W-1:0]   vec_o
);
  import vec_pred_load_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [ELEM_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    lane_q <= '0;
      else if (clear_i)                               lane_q <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(g)))    lane_q <= wr_data_i;
    end
    assign vec_o[g*ELEM_W +: ELEM_W] = lane_q;
  end
endmodule

// File: rtl/vpl_seq_ctrl.sv
module vpl_seq_ctrl #(
  parameter int unsigned N      = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned RIDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [N-1:0]      pred_i,
  input  logic [RIDX_W-1:0] dst_i,
  input  logic              req_ready_i,
  input  logic              rsp_valid_i,
  input  logic              pick_found_i,
  input  logic [IDX_W-1:0]  pick_idx_i,
  output logic [N-1:0]      pending_o,
  output logic [N-1:0]      pred_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [RIDX_W-1:0] dst_o,
  output logic              busy_o,
  output logic              req_valid_o,
  output logic              lane_wr_o,
  output logic              clear_o,
  output logic              rf_we_o,
  output logic              done_o
);
  import vec_pred_load_pkg::*;

  vpl_state_e        state_q;
  logic [N-1:0]      pending_q, pred_q, remaining;
  logic [ADDR_W-1:0] base_q;
  logic [RIDX_W-1:0] dst_q;

  assign remaining = pending_q & ~(N'(1) << pick_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pending_q <= '0;
      pred_q    <= '0;
      base_q    <= '0;
      dst_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pending_q <= pred_i;
          pred_q    <= pred_i;
          base_q    <= base_i;
          dst_q     <= dst_i;
          state_q   <= (|pred_i) ? ST_REQ : ST_WRITE;
        end
        ST_REQ:  if (req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          pending_q <= remaining;
          state_q   <= (|remaining) ? ST_REQ : ST_WRITE;
        end
        ST_WRITE: state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign req_valid_o = (state_q == ST_REQ);
  assign lane_wr_o   = (state_q == ST_WAIT) && rsp_valid_i;
  assign clear_o     = (state_q == ST_IDLE) && start_i;
  assign rf_we_o     = (state_q == ST_WRITE);
  assign done_o      = (state_q == ST_DONE);
  assign pending_o   = pending_q;
  assign pred_o      = pred_q;
  assign base_o      = base_q;
  assign dst_o       = dst_q;

  assert_req_active_lane_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (pick_found_i && pred_q[pick_idx_i]));
  assert_ascending_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_wr_o && (|remaining)) |=> (pick_idx_i > $past(pick_idx_i)));
  assert_empty_mask_skip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_o && !(|pred_i)) |=> rf_we_o);
  assert_write_then_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> (done_o && !rf_we_o));
  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_through_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o || done_o || req_valid_o) |-> busy_o);
  assert_dst_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(dst_o));
endmodule

// File: rtl/vec_pred_load.sv
module vec_pred_load #(
  parameter int unsigned VLEN   = 512,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned RIDX_W = 5,
  localparam int unsigned N     = VLEN / vec_pred_load_pkg::ELEM_W,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 start_i,
  input  logic [ADDR_W-1:0]                    base_addr_i,
  input  logic [N-1:0]                         pred_i,
  input  logic [RIDX_W-1:0]                    dst_idx_i,
  output logic                                 busy_o,
  output logic                                 mem_req_valid_o,
  input  logic                                 mem_req_ready_i,
  output logic [ADDR_W-1:0]                    mem_req_addr_o,
  input  logic                                 mem_rsp_valid_i,
  input  logic [vec_pred_load_pkg::ELEM_W-1:0] mem_rsp_data_i,
  output logic                                 rf_we_o,
  output logic [RIDX_W-1:0]                    rf_waddr_o,
  output logic [VLEN-1:0]                      rf_wdata_o,
  output logic                                 done_o
);
  import vec_pred_load_pkg::*;

  logic [N-1:0]      pending, pred_q;
  logic [ADDR_W-1:0] base_q;
  logic              pick_found, lane_wr, clear;
  logic [IDX_W-1:0]  pick_idx;
  logic [N*ELEM_W-1:0] vec;

  vpl_lane_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .mask_i (pending),
    .found_o(pick_found),
    .idx_o  (pick_idx)
  );

  vpl_seq_ctrl #(.N(N), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .base_i      (base_addr_i),
    .pred_i      (pred_i),
    .dst_i       (dst_idx_i),
    .req_ready_i (mem_req_ready_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .pick_found_i(pick_found),
    .pick_idx_i  (pick_idx),
    .pending_o   (pending),
    .pred_o      (pred_q),
    .base_o      (base_q),
    .dst_o       (rf_waddr_o),
    .busy_o      (busy_o),
    .req_valid_o (mem_req_valid_o),
    .lane_wr_o   (lane_wr),
    .clear_o     (clear),
    .rf_we_o     (rf_we_o),
    .done_o      (done_o)
  );

  vpl_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .base_i(base_q),
    .idx_i (pick_idx),
    .addr_o(mem_req_addr_o)
  );

  vpl_vec_assemble #(.N(N), .IDX_W(IDX_W)) u_vec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .wr_en_i  (lane_wr),
    .wr_idx_i (pick_idx),
    .wr_data_i(mem_rsp_data_i),
    .vec_o    (vec)
  );

  assign rf_wdata_o = VLEN'(vec);

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_valid_o && !rf_we_o && !done_o));
  for (genvar g = 0; g < N; g++) begin : g_zero_chk
    assert_inactive_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rf_we_o && !pred_q[g]) |-> (rf_wdata_o[g*ELEM_W +: ELEM_W] == '0));
  end
endmodule

// File: tb/vec_pred_load_tb_top.sv
`timescale 1ns/1ps
module vec_pred_load_tb_top;
  localparam int VLEN = 512;
  localparam int N    = VLEN / 64;
  localparam int AW   = 64;
  localparam int RW   = 5;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic            start_i;
  logic [AW-1:0]   base_addr_i;
  logic [N-1:0]    pred_i;
  logic [RW-1:0]   dst_idx_i;
  logic            busy_o, mem_req_valid_o, mem_req_ready_i;
  logic [AW-1:0]   mem_req_addr_o;
  logic            mem_rsp_valid_i;
  logic [63:0]     mem_rsp_data_i;
  logic            rf_we_o, done_o;
  logic [RW-1:0]   rf_waddr_o;
  logic [VLEN-1:0] rf_wdata_o;

  always #10 clk_i = ~clk_i;

  vec_pred_load #(.VLEN(VLEN), .ADDR_W(AW), .RIDX_W(RW)) dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [AW-1:0] exp_addr_q[$];
  bit            rsp_pend = 0;
  int            rsp_wait = 0;
  logic [AW-1:0] rsp_addr;
  bit            prev_valid = 0, prev_ready = 0;
  logic [AW-1:0] prev_addr;

  function automatic logic [63:0] mem_word(logic [63:0] a);
    return (a * 64'h9E37_79B9_7F4A_7C15) ^ {a[31:0], a[63:32]} ^ 64'hA5A5_0000_0000_5A5A;
  endfunction

  task automatic chk(bit ok, string req, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory agent: random ready, random response latency
  initial begin
    mem_req_ready_i = 1'b0;
    mem_rsp_valid_i = 1'b0;
    mem_rsp_data_i  = '0;
    forever begin
      @(negedge clk_i);
      mem_rsp_valid_i = 1'b0;
      if (prev_valid && prev_ready) begin
        if (exp_addr_q.size() == 0) begin
          chk(0, "R4 unexpected request", prev_addr, 0);
        end else begin
          logic [AW-1:0] e;
          e = exp_addr_q.pop_front();
          chk(prev_addr == e, "R2 request address", prev_addr, e);
        end
        rsp_pend = 1;
        rsp_wait = int'($urandom % 4);
        rsp_addr = prev_addr;
      end else if (rsp_pend) begin
        if (rsp_wait == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = mem_word(rsp_addr);
          rsp_pend = 0;
        end else rsp_wait--;
      end
      if (prev_valid && !prev_ready && rst_ni)
        chk(mem_req_valid_o && mem_req_addr_o == prev_addr, "R9 request hold", mem_req_addr_o, prev_addr);
      if (mem_req_valid_o && (rsp_pend || mem_rsp_valid_i))
        chk(0, "R4 request while response outstanding", 1, 0);
      mem_req_ready_i = ($urandom % 3) != 0;
      prev_valid = mem_req_valid_o;
      prev_ready = mem_req_ready_i;
      prev_addr  = mem_req_addr_o;
    end
  end

  task automatic run_cmd(logic [AW-1:0] base, logic [N-1:0] pred, logic [RW-1:0] dst, bit poke);
    logic [VLEN-1:0] exp_v;
    int c;
    exp_v = '0;
    exp_addr_q.delete();
    for (int i = 0; i < N; i++) begin
      if (pred[i]) begin
        exp_v[i*64 +: 64] = mem_word(base + AW'(8 * i));
        exp_addr_q.push_back(base + AW'(8 * i));
      end
    end
    @(negedge clk_i);
    start_i = 1'b1; base_addr_i = base; pred_i = pred; dst_idx_i = dst;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o, "R7 busy after accept", busy_o, 1);
    if (poke) begin
      start_i = 1'b1; base_addr_i = base ^ 64'h1000; pred_i = ~pred; dst_idx_i = ~dst;
      @(negedge clk_i);
      start_i = 1'b0;
      chk(busy_o, "R7 busy while start ignored", busy_o, 1);
    end
    c = 0;
    while (!rf_we_o && c < 400) begin
      chk(busy_o && !done_o, "R7 busy before write", {busy_o, done_o}, 2'b10);
      @(negedge clk_i);
      c++;
    end
    if (c >= 400) chk(0, "R6 write never seen", 0, 1);
    if (pred == '0 && !poke) chk(c == 0, "R5 empty mask write timing", c, 0);
    chk(rf_waddr_o == dst, "R6 write index", rf_waddr_o, dst);
    for (int i = 0; i < N; i++) begin
      if (pred[i])
        chk(rf_wdata_o[i*64 +: 64] == exp_v[i*64 +: 64], "R1 lane data", rf_wdata_o[i*64 +: 64], exp_v[i*64 +: 64]);
      else
        chk(rf_wdata_o[i*64 +: 64] == '0, "R3 inactive lane zero", rf_wdata_o[i*64 +: 64], 0);
    end
    chk(exp_addr_q.size() == 0, "R4 all active lanes requested", exp_addr_q.size(), 0);
    @(negedge clk_i);
    chk(done_o && busy_o && !rf_we_o, "R6 done after write", {done_o, busy_o, rf_we_o}, 3'b110);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R6 done single pulse", {done_o, busy_o}, 0);
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk_i);
        chk(!busy_o && !rf_we_o && !mem_req_valid_o, "R7 ignored start left no work",
            {busy_o, rf_we_o, mem_req_valid_o}, 0);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    rst_ni = 1'b0; start_i = 1'b0; base_addr_i = '0; pred_i = '0; dst_idx_i = '0;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !mem_req_valid_o && !rf_we_o && !done_o, "R8 reset state",
        {busy_o, mem_req_valid_o, rf_we_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_cmd(64'h0000_0000_1000_0000, '1, 5'd3, 0);                 // R1 R2 all lanes
    run_cmd(64'h0000_0000_2000_0040, '0, 5'd7, 0);                 // R5 empty mask
    run_cmd(64'h0000_0000_3000_0000, N'(1), 5'd1, 0);              // R4 lowest lane
    run_cmd(64'h0000_0000_3000_0100, N'(1) << (N - 1), 5'd31, 0);  // R4 highest lane
    run_cmd(64'h0000_0001_0000_0008, {(N/2){2'b01}}, 5'd10, 0);    // R3 alternating
    run_cmd(64'h0000_0001_0000_0800, {(N/2){2'b10}}, 5'd11, 0);    // R3 alternating
    run_cmd(64'hFFFF_FFFF_FFFF_FFF0, '1, 5'd0, 0);                 // R2 address wrap
    run_cmd(64'h0000_0000_4000_0000, {(N/2){2'b11}} ^ N'(6), 5'd20, 1); // R7 ignored start

    // R8 reset with a response outstanding
    exp_addr_q.delete();
    for (int i = 0; i < N; i++) exp_addr_q.push_back(64'h5000_0000 + AW'(8 * i));
    @(negedge clk_i);
    start_i = 1'b1; base_addr_i = 64'h5000_0000; pred_i = '1; dst_idx_i = 5'd9;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 50 && !rsp_pend; k++) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    exp_addr_q.delete();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      chk(!busy_o && !rf_we_o && !done_o && !mem_req_valid_o, "R8 response after reset ignored",
          {busy_o, rf_we_o, done_o, mem_req_valid_o}, 0);
    end

    for (int t = 0; t < 40; t++) begin
      logic [AW-1:0] b;
      b = {$urandom, $urandom};
      run_cmd(b, N'($urandom), RW'($urandom), (t % 7) == 3);
    end

    repeat (4) @(negedge clk_i);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule